// File: doc/BRIEF.md
# Segment Row Latch and Drive Level Selector

This block is the output stage of a column driver for a passive dot-matrix LCD. A loader elsewhere assembles one display row of column bits. When the load strobe falls, this block copies that row into its own holding register. The held row stays on the columns for the whole line period, while the loader fills the next row.

For every column the block emits a 2-bit code that tells an external analog stage which of four bias rails to connect. The code depends on three things: the held pixel bit, a frame alternation input that reverses the drive polarity so the panel sees no net DC, and an active-low blank input that forces every column to the same rail. The alternation and blank inputs act directly on the outputs. They are not held by the load strobe. The rails themselves are produced outside this block.

The load strobe is sampled on the system clock. A falling edge counts as a cycle in which the strobe is sampled low after it was sampled high in the cycle before. The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock through two stages.

Top module: `seg_line_drv`

## Requirements
- R1: In the clock cycle where `load_strobe` is sampled low after it was sampled high one cycle earlier, the held row takes the value of `row_in` sampled in that same cycle. `lvl_out` shows the new row after that clock edge.
- R2: In every other cycle the held row does not change. This covers the strobe held high, the strobe held low, and a rising strobe, whatever `row_in` does.
- R3: With `blank_n` high and `frame_alt` low, an on pixel (held bit 1) gives code 00 (rail V1) and an off pixel (held bit 0) gives code 01 (rail V3).
- R4: With `blank_n` high and `frame_alt` high, an on pixel gives code 11 (rail VEE) and an off pixel gives code 10 (rail V4).
- R5: While `blank_n` is low, every column gives code 00 (rail V1), whatever the held data and `frame_alt` are.
- R6: Blanking does not change the held row. A row loaded before or during blanking shows again once `blank_n` returns high.
- R7: `frame_alt` acts on the outputs within the same cycle and is not latched. Toggling it with no load strobe changes the polarity of every column at once.
- R8: After reset the held row is all zeros. With `blank_n` high and `frame_alt` low, every column then gives code 01.
- R9: Held bit i controls only `lvl_out[2*i+1:2*i]`. Column 0 is in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_in | input | 80 | Row assembled by the loader, bit i for column i |
| load_strobe | input | 1 | Line load strobe; its falling edge transfers the row |
| frame_alt | input | 1 | Frame alternation, selects drive polarity |
| blank_n | input | 1 | Active-low display blank, forces rail V1 |
| lvl_out | output | 160 | Two-bit rail code per column, column i at [2i+1:2i] |

## Verification
The bench loads a mixed hex pattern, its inverse, and single-bit rows at both end columns. Each row is checked under both alternation levels, which tells the four rail codes apart and shows that each column follows only its own bit. During the strobe's high phase and after the fall, `row_in` is changed to decoy values. This shows that the capture takes the sample from the falling cycle, and not one from before or after it. Held-high, held-low and rising strobe phases with changing data show that nothing else loads the row. Loading during blanking and then unblanking shows that the override masks the outputs without touching the held data.

// File: rtl/seg_line_pkg.sv
package seg_line_pkg;

  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    RAIL_V1  = 2'b00,
    RAIL_V3  = 2'b01,
    RAIL_V4  = 2'b10,
    RAIL_VEE = 2'b11
  } rail_e;

  // Rail choice for one column from its held bit, polarity and blank input.
  function automatic rail_e pick_rail(input logic pix, input logic alt, input logic blank_n);
    rail_e r;
    if (!blank_n) begin
      r = RAIL_V1;
    end else begin
      unique case ({alt, pix})
        2'b00:   r = RAIL_V3;
        2'b01:   r = RAIL_V1;
        2'b10:   r = RAIL_V4;
        default: r = RAIL_VEE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/seg_strobe_fall.sv
module seg_strobe_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);

  logic strobe_q;
  logic strobe_d;

  always_comb begin
    strobe_d = strobe;
    fall     = strobe_q & ~strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  // R1: a fall is reported only when the strobe was high in the cycle before
  a_r1_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> ($past(strobe) && !strobe));

  // R2: falls cannot be reported in two cycles back to back
  a_r2_no_double_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/seg_row_hold.sv
module seg_row_hold #(
  parameter int unsigned COLS = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [COLS-1:0] row_d,
  output logic [COLS-1:0] row_q
);

  logic [COLS-1:0] row_nxt;

  always_comb begin
    row_nxt = row_q;
    if (cap_en) begin
      row_nxt = row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else begin
      row_q <= row_nxt;
    end
  end

  // R1: the held row takes the data presented in the capture cycle
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (row_q == $past(row_d)));

  // R2: with no capture the held row keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(row_q));

endmodule

// File: rtl/seg_rail_enc.sv
module seg_rail_enc
  import seg_line_pkg::*;
#(
  parameter int unsigned COLS = 80
) (
  input  logic                  alt,
  input  logic                  blank_n,
  input  logic [COLS-1:0]       pix,
  output logic [COLS*LVL_W-1:0] codes
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    rail_e col_rail;
    always_comb begin
      col_rail = pick_rail(pix[c], alt, blank_n);
    end
    assign codes[c*LVL_W +: LVL_W] = col_rail;
  end

endmodule

// File: rtl/seg_line_drv.sv
module seg_line_drv
  import seg_line_pkg::*;
#(
  parameter int unsigned COLS = 80,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [COLS-1:0]       row_in,
  input  logic                  load_strobe,
  input  logic                  frame_alt,
  input  logic                  blank_n,
  output logic [COLS*LVL_W-1:0] lvl_out
);

  localparam int unsigned OUT_W = COLS * LVL_W;

  logic            rst_sync_n;
  logic            load_fall;
  logic [COLS-1:0] held_row;
  logic [OUT_W-1:0] enc_codes;

  seg_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  seg_strobe_fall u_fall (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .strobe (load_strobe),
    .fall   (load_fall)
  );

  seg_row_hold #(.COLS(COLS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (load_fall),
    .row_d  (row_in),
    .row_q  (held_row)
  );

  seg_rail_enc #(.COLS(COLS)) u_enc (
    .alt     (frame_alt),
    .blank_n (blank_n),
    .pix     (held_row),
    .codes   (enc_codes)
  );

  assign lvl_out = enc_codes;

  // R5: blanking drives every column to rail V1
  a_r5_blank_all_v1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !blank_n |-> (lvl_out == '0));

  for (genvar c = 0; c < COLS; c++) begin : g_chk
    // R3 and R4: upper code bit follows polarity while not blanked
    a_r4_polarity: assert property (@(posedge clk) disable iff (!rst_sync_n)
      blank_n |-> (lvl_out[c*LVL_W+1] == frame_alt));
    // R9: selected rail (V1 or VEE) exactly when the column's own held bit is set
    a_r9_own_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
      blank_n |-> ((lvl_out[c*LVL_W+1] == lvl_out[c*LVL_W]) == held_row[c]));
  end

endmodule

// File: tb/seg_line_drv_bench.sv
module seg_line_drv_bench;

  localparam int COLS = 80;
  localparam int OW   = 2 * COLS;

  logic            clk;
  logic            rst_n;
  logic [COLS-1:0] row_in;
  logic            load_strobe;
  logic            frame_alt;
  logic            blank_n;
  logic [OW-1:0]   lvl_out;

  int checks;
  int failures;
  bit done;

  seg_line_drv u_seg_line_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_in      (row_in),
    .load_strobe (load_strobe),
    .frame_alt   (frame_alt),
    .blank_n     (blank_n),
    .lvl_out     (lvl_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected codes from the requirements: V1=00 V3=01 V4=10 VEE=11
  function automatic logic [OW-1:0] expect_codes(input logic [COLS-1:0] row,
                                                 input logic alt, input logic bl_n);
    logic [OW-1:0] e;
    for (int i = 0; i < COLS; i++) begin
      if (!bl_n)     e[2*i +: 2] = 2'b00;
      else if (!alt) e[2*i +: 2] = row[i] ? 2'b00 : 2'b01;
      else           e[2*i +: 2] = row[i] ? 2'b11 : 2'b10;
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [COLS-1:0] row);
    logic [OW-1:0] exp_v;
    exp_v = expect_codes(row, frame_alt, blank_n);
    checks++;
    if (lvl_out !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, lvl_out, exp_v);
    end
  endtask

  // Strobe high with a decoy row, fall with the real row, then a decoy after
  task automatic pulse_load(input logic [COLS-1:0] row);
    @(negedge clk); load_strobe = 1'b1; row_in = ~row;
    @(negedge clk); load_strobe = 1'b0; row_in = row;
    @(negedge clk); row_in = {COLS{1'b1}} ^ {row[COLS-2:0], row[COLS-1]};
  endtask

  task automatic t_reset();
    frame_alt = 1'b0; blank_n = 1'b1;
    @(negedge clk);
    check("R8 reset clears row", '0);
  endtask

  task automatic t_load_polarity();
    logic [COLS-1:0] a;
    a = 80'hA5C3_0F1E_9B27_64D8_3CF0;
    pulse_load(a);
    frame_alt = 1'b0; #1;
    check("R1 R3 capture at fall, alt low", a);
    frame_alt = 1'b1; #1;
    check("R4 R7 alt high no reload", a);
    pulse_load(~a);
    check("R1 R4 inverse row", ~a);
    frame_alt = 1'b0; #1;
    check("R3 R7 alt back low", ~a);
  endtask

  task automatic t_no_capture();
    logic [COLS-1:0] a;
    a = 80'h1234_5678_9ABC_DEF0_1357;
    pulse_load(a);
    @(negedge clk); load_strobe = 1'b1; row_in = 80'hFFFF_0000_FFFF_0000_FFFF;
    @(negedge clk);
    check("R2 rising strobe", a);
    row_in = 80'h0;
    @(negedge clk); row_in = 80'hDEAD_BEEF_0000_1111_2222;
    @(negedge clk);
    check("R2 strobe held high", a);
    load_strobe = 1'b0; row_in = a;
    @(negedge clk); row_in = 80'h5555_5555_5555_5555_5555;
    @(negedge clk); row_in = 80'hAAAA_AAAA_AAAA_AAAA_AAAA;
    @(negedge clk);
    check("R2 strobe held low", a);
  endtask

  task automatic t_blank();
    logic [COLS-1:0] a, b;
    a = 80'hF0F0_1234_CAFE_0001_8000;
    b = 80'h0F0F_4321_BEEF_8000_0001;
    pulse_load(a);
    blank_n = 1'b0; frame_alt = 1'b1; #1;
    check("R5 blank alt high", a);
    frame_alt = 1'b0; #1;
    check("R5 blank alt low", a);
    blank_n = 1'b1; #1;
    check("R6 unblank restores row", a);
    blank_n = 1'b0;
    pulse_load(b);
    check("R5 blank during load", b);
    blank_n = 1'b1; #1;
    check("R6 row loaded while blanked", b);
  endtask

  task automatic t_columns();
    logic [COLS-1:0] lo, hi;
    lo = '0; lo[0] = 1'b1;
    hi = '0; hi[COLS-1] = 1'b1;
    frame_alt = 1'b0;
    pulse_load(lo);
    check("R9 column 0 only", lo);
    frame_alt = 1'b1; #1;
    check("R9 column 0 alt high", lo);
    pulse_load(hi);
    check("R9 last column only", hi);
    frame_alt = 1'b0; #1;
    check("R9 last column alt low", hi);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; row_in = '1; load_strobe = 1'b0; frame_alt = 1'b0; blank_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_polarity();
    t_no_capture();
    t_blank();
    t_columns();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule